// File: doc/BRIEF.md
# Grouped-Source Vectored Interrupt Controller

This block collects 43 level-sensitive peripheral request lines and presents the single most urgent one to a processor as a 12-bit event code, a 4-bit priority level and an interrupt-request flag. Software sets up the controller through a small register bus that completes every access in one cycle. Each source has a fixed event code and is gated by one or two configuration entries. One is a 4-bit priority field, which may serve a lone source or a whole family of related sources. Some sources also need a bit in a 32-bit mask register.

The mask register has two addresses. Writing ones to one address turns bits on. Writing ones to the other turns bits off. A source takes part in arbitration only when every entry that governs it is nonzero. Its level is then the value of its priority field. The winner is registered, so the outputs follow a change on the request lines or in the registers after one clock edge.

Top module: `grp_vic`

## Requirements
- R1: After reset all configuration registers read zero, and irq, irq_code and irq_level are zero.
- R2: Four 16-bit priority registers sit at offsets 0x04 (bank A), 0x08 (B), 0x0C (C) and 0x10 (D). Each takes wdata[15:0] and reads back zero-extended. The field at bits 15:12 is the first listed entry and bits 3:0 the last. A: timer0, timer1, timer-2 family, clock family. B: watchdog, refresh family, serial-1 family, unused. C: general I/O, DMA family, FIFO-serial family, debug. D: external lines 0 to 3. A 32-bit priority register at 0x20 has bits 31:16 unused, then timer4 (15:12), timer3 (11:8), PCI family (7:4) and PCI system error (3:0).
- R3: A write to 0x40 ORs wdata into the mask register. A read of either 0x40 or 0x44 returns the mask value.
- R4: A write to 0x44 clears every mask bit where wdata is 1 and leaves the others.
- R5: A source is enabled only when its priority field is nonzero and, if it has a mask bit, that bit is 1. The mask bits are timer4 = bit 9, timer3 = bit 8, PCI error = 7, power-down = 6, power-on = 5, PCI DMA0..3 = 4..1 and PCI system error = 0.
- R6: A family field enables every member. The families are timer-2 (2 members), clock (3), serial-1 (4), FIFO-serial (4), refresh (2), DMA (9) and PCI (7).
- R7: src_req bit to event code: 0:0x400, 1:0x420, 2:0x440, 3:0x460, 4..6:0x480/0x4A0/0x4C0, 7..10:0x4E0/0x500/0x520/0x540, 11:0x560, 12..13:0x580/0x5A0, 14:0x620, 15..18:0x640/0x660/0x680/0x6A0, 19:0x6C0, 20..23:0x780/0x7A0/0x7C0/0x7E0, 24..27:0x700/0x720/0x740/0x760, 28:0x600, 29:0xB00, 30:0xB80, 31:0xA00, 32..38:0xAE0/0xAC0/0xAA0/0xA80/0xA60/0xA40/0xA20, 39..42:0x240/0x2A0/0x300/0x360.
- R8: Among the enabled sources whose request is high, the one with the highest level wins.
- R9: Among winners with equal levels, the lowest src_req bit wins.
- R10: The outputs are registered. They reflect the requests and registers present at the previous clock edge. With no enabled request pending, irq, irq_code and irq_level are zero.
- R11: Writes to unused priority fields and unused mask bits are stored and read back, but they enable no source.
- R12: A read of any other address returns zero. A write to any other address changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 8 | Byte offset of the register access |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe; reg_rdata is zero when low |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, same cycle |
| src_req | input | 43 | Level request lines, one per source |
| irq | output | 1 | An enabled request is pending |
| irq_code | output | 12 | Event code of the winner |
| irq_level | output | 4 | Priority level of the winner |

## Verification
The bench attacks the double gate on the timer-4 and PCI sources. A design that used only the priority field would raise an interrupt while the mask bit is clear. It drives a family field and then requests a member that is not the first, because a controller that fans out only to the first member stays silent. Equal-level requests on adjacent lines expose a tie-break that favours the higher index. The bench also fills unused fields, unused mask bits and undecoded offsets with ones. A decode that aliases addresses, or that maps a spare field onto a real source, then shows up as a spurious interrupt or as a corrupted read-back.

// File: rtl/grp_vic.sv
`timescale 1ns/1ps
module grp_vic #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic [42:0]   src_req,
  output logic          irq,
  output logic [11:0]   irq_code,
  output logic [3:0]    irq_level
);
  localparam int NSRC = 43;
  localparam int IW   = $clog2(NSRC);
  localparam int NFLD = 20;

  localparam logic [AW-1:0] A_PRA = AW'(8'h04);
  localparam logic [AW-1:0] A_PRB = AW'(8'h08);
  localparam logic [AW-1:0] A_PRC = AW'(8'h0C);
  localparam logic [AW-1:0] A_PRD = AW'(8'h10);
  localparam logic [AW-1:0] A_PRW = AW'(8'h20);
  localparam logic [AW-1:0] A_MST = AW'(8'h40);
  localparam logic [AW-1:0] A_MCL = AW'(8'h44);

  // {code[11:0], field[4:0], has_mask, mask_bit[4:0]}
  function automatic logic [22:0] src_info(input int i);
    logic [22:0] r;
    case (i)
      0:  r = {12'h400, 5'd0,  6'h00};
      1:  r = {12'h420, 5'd1,  6'h00};
      2:  r = {12'h440, 5'd2,  6'h00};
      3:  r = {12'h460, 5'd2,  6'h00};
      4:  r = {12'h480, 5'd3,  6'h00};
      5:  r = {12'h4A0, 5'd3,  6'h00};
      6:  r = {12'h4C0, 5'd3,  6'h00};
      7:  r = {12'h4E0, 5'd6,  6'h00};
      8:  r = {12'h500, 5'd6,  6'h00};
      9:  r = {12'h520, 5'd6,  6'h00};
      10: r = {12'h540, 5'd6,  6'h00};
      11: r = {12'h560, 5'd4,  6'h00};
      12: r = {12'h580, 5'd5,  6'h00};
      13: r = {12'h5A0, 5'd5,  6'h00};
      14: r = {12'h620, 5'd8,  6'h00};
      15: r = {12'h640, 5'd9,  6'h00};
      16: r = {12'h660, 5'd9,  6'h00};
      17: r = {12'h680, 5'd9,  6'h00};
      18: r = {12'h6A0, 5'd9,  6'h00};
      19: r = {12'h6C0, 5'd9,  6'h00};
      20: r = {12'h780, 5'd9,  6'h00};
      21: r = {12'h7A0, 5'd9,  6'h00};
      22: r = {12'h7C0, 5'd9,  6'h00};
      23: r = {12'h7E0, 5'd9,  6'h00};
      24: r = {12'h700, 5'd10, 6'h00};
      25: r = {12'h720, 5'd10, 6'h00};
      26: r = {12'h740, 5'd10, 6'h00};
      27: r = {12'h760, 5'd10, 6'h00};
      28: r = {12'h600, 5'd11, 6'h00};
      29: r = {12'hB00, 5'd17, 6'h28};
      30: r = {12'hB80, 5'd16, 6'h29};
      31: r = {12'hA00, 5'd19, 6'h20};
      32: r = {12'hAE0, 5'd18, 6'h27};
      33: r = {12'hAC0, 5'd18, 6'h26};
      34: r = {12'hAA0, 5'd18, 6'h25};
      35: r = {12'hA80, 5'd18, 6'h24};
      36: r = {12'hA60, 5'd18, 6'h23};
      37: r = {12'hA40, 5'd18, 6'h22};
      38: r = {12'hA20, 5'd18, 6'h21};
      39: r = {12'h240, 5'd12, 6'h00};
      40: r = {12'h2A0, 5'd13, 6'h00};
      41: r = {12'h300, 5'd14, 6'h00};
      42: r = {12'h360, 5'd15, 6'h00};
      default: r = '0;
    endcase
    return r;
  endfunction

  logic [15:0] pri_a, pri_b, pri_c, pri_d;
  logic [31:0] pri_w, msk;

  logic hit;
  assign hit = (reg_addr == A_PRA) || (reg_addr == A_PRB) || (reg_addr == A_PRC) ||
               (reg_addr == A_PRD) || (reg_addr == A_PRW) || (reg_addr == A_MST) ||
               (reg_addr == A_MCL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pri_a <= '0; pri_b <= '0; pri_c <= '0; pri_d <= '0;
      pri_w <= '0; msk   <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        A_PRA: pri_a <= reg_wdata[15:0];
        A_PRB: pri_b <= reg_wdata[15:0];
        A_PRC: pri_c <= reg_wdata[15:0];
        A_PRD: pri_d <= reg_wdata[15:0];
        A_PRW: pri_w <= reg_wdata;
        A_MST: msk   <= msk | reg_wdata;
        A_MCL: msk   <= msk & ~reg_wdata;
        default: ;
      endcase
    end
  end

  logic [31:0] rd_mux;
  always_comb begin
    case (reg_addr)
      A_PRA:        rd_mux = {16'h0, pri_a};
      A_PRB:        rd_mux = {16'h0, pri_b};
      A_PRC:        rd_mux = {16'h0, pri_c};
      A_PRD:        rd_mux = {16'h0, pri_d};
      A_PRW:        rd_mux = pri_w;
      A_MST, A_MCL: rd_mux = msk;
      default:      rd_mux = '0;
    endcase
  end
  assign reg_rdata = reg_rd ? rd_mux : '0;

  logic [4*NFLD-1:0] fld_all;
  assign fld_all = {pri_a, pri_b, pri_c, pri_d, pri_w[15:0]};

  logic [3:0]  eff_lvl  [NSRC];
  logic [11:0] code_tab [NSRC];

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    localparam logic [22:0] INFO = src_info(g);
    localparam int FLD  = int'(INFO[10:6]);
    localparam bit HASM = INFO[5];
    localparam int MBIT = int'(INFO[4:0]);
    logic [3:0] lvl;
    logic       gate;
    assign lvl  = fld_all[4*NFLD-1-4*FLD -: 4];
    assign gate = (lvl != 4'd0) && (!HASM || msk[MBIT]);
    assign eff_lvl[g]  = gate ? lvl : 4'd0;
    assign code_tab[g] = INFO[22:11];
  end

  logic [3:0]    best_lvl;
  logic [IW-1:0] best_idx;
  always_comb begin
    best_lvl = '0;
    best_idx = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (src_req[i] && (eff_lvl[i] > best_lvl)) begin
        best_lvl = eff_lvl[i];
        best_idx = IW'(i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq <= 1'b0; irq_code <= '0; irq_level <= '0;
    end else begin
      irq       <= (best_lvl != 4'd0);
      irq_code  <= (best_lvl != 4'd0) ? code_tab[best_idx] : 12'h000;
      irq_level <= best_lvl;
    end
  end

  // R3
  mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_MST) |=> (msk == ($past(msk) | $past(reg_wdata))));

  // R4
  mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_MCL) |=> (msk == ($past(msk) & ~$past(reg_wdata))));

  // R12
  stray_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !hit) |=> ($stable(pri_a) && $stable(pri_b) && $stable(pri_c) &&
                          $stable(pri_d) && $stable(pri_w) && $stable(msk)));

  // R10
  idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_req == '0) |=> (!irq && irq_code == 12'h000 && irq_level == 4'd0));

  // R8
  live_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irq_level != 4'd0 && irq_code != 12'h000));
endmodule

// File: tb/grp_vic_bench.sv
`timescale 1ns/1ps
module grp_vic_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [42:0] src_req = '0;
  logic        irq;
  logic [11:0] irq_code;
  logic [3:0]  irq_level;

  always #2 clk = ~clk;

  grp_vic u_grp_vic (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .src_req(src_req),
    .irq(irq), .irq_code(irq_code), .irq_level(irq_level)
  );

  typedef struct {
    logic        irq;
    logic [11:0] code;
    logic [3:0]  lvl;
    string       tag;
  } item_t;

  item_t sb[$];
  item_t it;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  function automatic logic [42:0] bitn(input int n);
    return 43'(1) << n;
  endfunction

  task automatic note(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      it = sb.pop_front();
      note({irq, irq_code, irq_level} == {it.irq, it.code, it.lvl}, it.tag,
           {15'h0, irq, irq_code, irq_level}, {15'h0, it.irq, it.code, it.lvl});
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
    reg_addr = a; reg_rd = 1'b1;
    #1;
    note(reg_rdata == exp, tag, reg_rdata, exp);
    reg_rd = 1'b0;
  endtask

  task automatic drive(input logic [42:0] req, input logic e_irq, input logic [11:0] e_code,
                       input logic [3:0] e_lvl, input string tag);
    item_t n;
    src_req = req;
    n.irq = e_irq; n.code = e_code; n.lvl = e_lvl; n.tag = tag;
    sb.push_back(n);
    @(negedge clk);
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    note({irq, irq_code, irq_level} == 17'h0, "R1 outputs after reset", {15'h0, irq, irq_code, irq_level}, 32'h0);
    rd_chk(8'h04, 32'h0, "R1 bank A reset");
    rd_chk(8'h20, 32'h0, "R1 wide reset");
    rd_chk(8'h40, 32'h0, "R1 mask reset");

    drive(bitn(0), 0, 12'h000, 4'd0, "R5 request with zero field");
    wr(8'h04, 32'hFFFF_5000);
    rd_chk(8'h04, 32'h0000_5000, "R2 bank A low half only");
    drive(bitn(0), 1, 12'h400, 4'd5, "R7 timer0 code");

    wr(8'h04, 32'h5200);
    drive(bitn(0) | bitn(1), 1, 12'h400, 4'd5, "R8 higher level timer0");
    wr(8'h04, 32'h2900);
    drive(bitn(0) | bitn(1), 1, 12'h420, 4'd9, "R8 higher level timer1");
    wr(8'h04, 32'h4400);
    drive(bitn(0) | bitn(1), 1, 12'h400, 4'd4, "R9 tie to lower bit");
    drive(bitn(1), 1, 12'h420, 4'd4, "R9 single timer1");

    wr(8'h04, 32'h0030);
    drive(bitn(3), 1, 12'h460, 4'd3, "R6 timer-2 second member");
    drive(bitn(2), 1, 12'h440, 4'd3, "R7 timer-2 underflow code");
    wr(8'h04, 32'h0037);
    drive(bitn(2) | bitn(6), 1, 12'h4C0, 4'd7, "R6 clock family third member");
    wr(8'h04, 32'h0);

    wr(8'h0C, 32'h0600);
    drive(bitn(21), 1, 12'h7A0, 4'd6, "R6 DMA member 5");
    drive(bitn(19), 1, 12'h6C0, 4'd6, "R6 DMA address error");
    drive(bitn(15), 1, 12'h640, 4'd6, "R7 DMA end 0 code");
    wr(8'h0C, 32'h0);

    wr(8'h08, 32'h1000);
    drive(bitn(11), 1, 12'h560, 4'd1, "R7 watchdog code");
    wr(8'h08, 32'h000F);
    rd_chk(8'h08, 32'h000F, "R11 unused field stored");
    drive({43{1'b1}}, 0, 12'h000, 4'd0, "R11 unused field enables nothing");
    wr(8'h08, 32'h0);

    wr(8'h20, 32'h0000_A000);
    rd_chk(8'h20, 32'h0000_A000, "R2 wide register");
    drive(bitn(30), 0, 12'h000, 4'd0, "R5 timer4 mask clear blocks");
    wr(8'h40, 32'h200);
    rd_chk(8'h40, 32'h200, "R3 mask set");
    drive(bitn(30), 1, 12'hB80, 4'd10, "R5 timer4 both gates open");
    wr(8'h44, 32'h200);
    rd_chk(8'h40, 32'h0, "R4 mask clear");
    drive(bitn(30), 0, 12'h000, 4'd0, "R4 timer4 off after clear");

    wr(8'h40, 32'h3);
    wr(8'h40, 32'h4);
    rd_chk(8'h44, 32'h7, "R3 set accumulates, read at clear address");
    wr(8'h44, 32'h2);
    rd_chk(8'h40, 32'h5, "R4 clear only selected bits");

    wr(8'h40, 32'hFFFF_FC00);
    rd_chk(8'h40, 32'hFFFF_FC05, "R11 unused mask bits stored");
    wr(8'h20, 32'hF0F0_0000);
    rd_chk(8'h20, 32'hF0F0_0000, "R11 unused wide fields stored");
    drive({43{1'b1}}, 0, 12'h000, 4'd0, "R11 unused wide fields and bits enable nothing");

    wr(8'h20, 32'h0000_0080);
    drive(bitn(37), 1, 12'hA40, 4'd8, "R6 PCI family DMA2 with mask bit 2");
    drive(bitn(35), 0, 12'h000, 4'd0, "R5 PCI DMA0 mask bit 4 clear");

    wr(8'h30, 32'hFFFF_FFFF);
    wr(8'h00, 32'h1234);
    rd_chk(8'h30, 32'h0, "R12 undecoded read zero");
    rd_chk(8'h20, 32'h80, "R12 wide untouched");
    rd_chk(8'h40, 32'hFFFF_FC05, "R12 mask untouched");
    rd_chk(8'h04, 32'h0, "R12 bank A untouched");

    wr(8'h10, 32'h000C);
    drive(bitn(42) | bitn(37), 1, 12'h360, 4'd12, "R8 external line 3 over PCI");
    drive('0, 0, 12'h000, 4'd0, "R10 idle after drop");
    src_req = bitn(42);
    #1;
    note(irq == 1'b0, "R10 no change before edge", {31'h0, irq}, 32'h0);
    drive(bitn(42), 1, 12'h360, 4'd12, "R10 after one edge");
    drive('0, 0, 12'h000, 4'd0, "R10 final idle");

    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule